// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Break Detection

This block receives asynchronous serial characters on a single line input. It uses a 16x oversampling tick supplied by an external rate generator. The line first passes through a two-stage synchronizer. A start bit is accepted on a high-to-low transition and confirmed at its centre. Later bits are sampled at their centres: eight data bits sent least significant bit first, an optional parity bit with selectable odd or even sense, and one stop bit. Each completed character appears on a valid/ready output. Parity and framing problems are reported on sticky status flags.

The block tells a line break apart from an ordinary framing error. If the data bits, the parity bit (when enabled) and the stop bit all sample low, the frame is treated as a break. The break flag is raised, the framing flag is left alone and no character is delivered. The receiver then ignores the line until it has been high for a full bit time, emits a one-cycle end-of-break pulse and resumes hunting for start bits.

Back-pressure on the character output: `rx_valid` stays high and `rx_data` stays stable until a cycle in which `rx_valid` and `rx_ready` are both high. If a new character completes before the old one is taken, the new one replaces it and `rx_valid` stays high. The parity configuration pins must be held steady while a frame is in flight.

Top module: `uart_brk_rx`

## Requirements
- R1: A low pulse on `rxd` that is no longer at the start-bit centre (8 ticks after it is seen) is rejected: no character and no flag results.
- R2: A frame of start (0), eight data bits least significant bit first, optional parity and stop (1) delivers the data byte on `rx_data` with `rx_valid` set.
- R3: Once set, `rx_valid` and `rx_data` hold until a cycle with `rx_valid` and `rx_ready` both high. That cycle clears `rx_valid`.
- R4: With `par_en`=1, a parity error is flagged when the data bits plus the parity bit hold an odd number of ones while `par_odd`=0, or an even number while `par_odd`=1. With `par_en`=0 no parity bit is expected and `par_err` is never set.
- R5: A stop bit sampled as 0 in a frame that is not a break sets `frm_err`. This happens at the stop-bit centre, before the stop-bit period ends. The character is still delivered on `rx_data`.
- R6: When all data bits, the parity bit (if enabled) and the stop bit sample 0, `brk_flag` is set, `frm_err` stays 0 and `rx_valid` is not set.
- R7: After a break, no new start bit is accepted until `rxd` has been high for 16 consecutive ticks. At that moment `brk_end` pulses for exactly one clock. A low glitch during the wait restarts the count.
- R8: A one-cycle `sta_clr` clears `par_err`, `frm_err` and `brk_flag`, and leaves `rx_valid` and `rx_data` untouched.
- R9: After reset, `rx_valid`, `par_err`, `frm_err`, `brk_flag` and `brk_end` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | 1 = frame carries a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| sta_clr | input | 1 | Clears the error and break flags |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Character available |
| rx_ready | input | 1 | Consumer takes the character when high with rx_valid |
| par_err | output | 1 | Sticky parity error flag |
| frm_err | output | 1 | Sticky framing error flag |
| brk_flag | output | 1 | Sticky break-received flag |
| brk_end | output | 1 | One-cycle pulse when the line recovers after a break |

## Verification
Frames are driven with alternating and asymmetric bytes such as 0xA5 and 0x80, so that a reversed bit order or a slipped sample point gives a wrong byte. Each parity sense is sent with both a correct and a wrong parity bit. Zero-valued frames are varied between a genuine break, a frame whose parity bit alone is high (a framing error with a parity error, not a break), and a zero stop after a non-zero byte. This separates the break path from the framing path. Directed cases cover a short false start, a low glitch during break recovery, the framing flag appearing before the stop bit ends, and a withheld `rx_ready`.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_BRKW
  } rx_st_e;

  typedef struct packed {
    logic done;     // character finished (not a break)
    logic perr;     // parity mismatch on that character
    logic ferr;     // stop bit low on that character
    logic brk;      // break frame recognised
    logic brk_end;  // line recovered after break
  } rx_evt_t;
endpackage

// File: rtl/uart_brk_sync.sv
module uart_brk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_brk_frame.sv
module uart_brk_frame
  import uart_brk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic              par_en,
  input  logic              par_odd,
  output logic [DATA_W-1:0] data_o,
  output rx_evt_t           evt_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] TOPB = BIT_W'(DATA_W - 1);

  rx_st_e            st;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [DATA_W-1:0] shreg;
  logic              parbit;
  logic              armed;
  logic              ones;

  assign ones   = ^{shreg, parbit};
  assign data_o = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      shreg  <= '0;
      parbit <= 1'b0;
      armed  <= 1'b0;
      evt_o  <= '0;
    end else begin
      evt_o <= '0;
      if (tick) begin
        unique case (st)
          RX_IDLE: begin
            if (rxd_s) armed <= 1'b1;
            else if (armed) begin
              st  <= RX_START;
              cnt <= '0;
            end
          end
          RX_START: begin
            if (cnt == MID) begin
              cnt   <= '0;
              bitn  <= '0;
              armed <= 1'b0;
              st    <= rxd_s ? RX_IDLE : RX_DATA;
            end else cnt <= cnt + 1'b1;
          end
          RX_DATA: begin
            if (cnt == LAST) begin
              cnt   <= '0;
              shreg <= {rxd_s, shreg[DATA_W-1:1]};
              if (bitn == TOPB) begin
                parbit <= 1'b0;
                st     <= par_en ? RX_PAR : RX_STOP;
              end else bitn <= bitn + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          RX_PAR: begin
            if (cnt == LAST) begin
              cnt    <= '0;
              parbit <= rxd_s;
              st     <= RX_STOP;
            end else cnt <= cnt + 1'b1;
          end
          RX_STOP: begin
            if (cnt == LAST) begin
              cnt <= '0;
              if (!rxd_s && shreg == '0 && !parbit) begin
                evt_o.brk <= 1'b1;
                st        <= RX_BRKW;
              end else begin
                evt_o.done <= 1'b1;
                evt_o.perr <= par_en & (ones ^ par_odd);
                evt_o.ferr <= ~rxd_s;
                armed      <= 1'b0;
                st         <= RX_IDLE;
              end
            end else cnt <= cnt + 1'b1;
          end
          RX_BRKW: begin
            if (!rxd_s) cnt <= '0;
            else if (cnt == LAST) begin
              cnt           <= '0;
              evt_o.brk_end <= 1'b1;
              armed         <= 1'b1;
              st            <= RX_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R7: end-of-break is a single-cycle event
  p_brkend_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o.brk_end |=> !evt_o.brk_end);

  // R1: a frame leaves idle only while the synchronized line is low
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_IDLE && tick && rxd_s) |=> st == RX_IDLE);
endmodule

// File: rtl/uart_brk_status.sv
module uart_brk_status
  import uart_brk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rx_evt_t           evt_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sta_clr,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  output logic              frm_err,
  output logic              brk_flag,
  output logic              brk_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      brk_flag <= 1'b0;
      brk_end  <= 1'b0;
    end else begin
      brk_end <= evt_i.brk_end;
      if (evt_i.done) begin
        rx_data  <= data_i;
        rx_valid <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
      par_err  <= (par_err  & ~sta_clr) | evt_i.perr;
      frm_err  <= (frm_err  & ~sta_clr) | evt_i.ferr;
      brk_flag <= (brk_flag & ~sta_clr) | evt_i.brk;
    end
  end

  p_valid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !evt_i.done) |=> $stable(rx_data));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_clr && !evt_i.perr && !evt_i.ferr && !evt_i.brk)
      |=> (!par_err && !frm_err && !brk_flag));

  p_brk_no_frm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.brk && !frm_err) |=> (brk_flag && !frm_err));
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import uart_brk_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OSR      = 16,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              sta_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              par_err,
  output logic              frm_err,
  output logic              brk_flag,
  output logic              brk_end
);
  logic              rxd_s;
  logic [DATA_W-1:0] fr_data;
  rx_evt_t           evt;

  uart_brk_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (rxd),
    .q    (rxd_s)
  );

  uart_brk_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (baud_tick),
    .rxd_s  (rxd_s),
    .par_en (par_en),
    .par_odd(par_odd),
    .data_o (fr_data),
    .evt_o  (evt)
  );

  uart_brk_status #(.DATA_W(DATA_W)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt),
    .data_i  (fr_data),
    .sta_clr (sta_clr),
    .rx_ready(rx_ready),
    .rx_data (rx_data),
    .rx_valid(rx_valid),
    .par_err (par_err),
    .frm_err (frm_err),
    .brk_flag(brk_flag),
    .brk_end (brk_end)
  );
endmodule

// File: tb/uart_brk_rx_tb.sv
module uart_brk_rx_tb_top;
  localparam int BITC = 32; // clocks per bit: tick every 2 clocks, 16 ticks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rxd = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, sta_clr = 1'b0, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, par_err, frm_err, brk_flag, brk_end;

  int n_chk = 0, n_bad = 0, n_end = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) tick <= ~tick;
  always @(posedge clk) if (rst_n && brk_end) n_end++;

  uart_brk_rx dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(tick), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .sta_clr(sta_clr),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .par_err(par_err), .frm_err(frm_err), .brk_flag(brk_flag),
    .brk_end(brk_end)
  );

  // [15:8] data, [7] par_en, [6] par_odd, [5] parity bit sent, [4] stop bit sent,
  // [3] exp valid, [2] exp par_err, [1] exp frm_err, [0] exp brk
  localparam logic [15:0] VEC [10] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    sta_clr = 1'b1; rx_ready = 1'b1;
    @(negedge clk);
    sta_clr = 1'b0; rx_ready = 1'b0;
  endtask

  // sends start, data, optional parity; stop bit left to caller
  task automatic send_head(input logic [7:0] d, input logic pe, input logic pb);
    hold(1'b0, BITC);
    for (int i = 0; i < 8; i++) hold(d[i], BITC);
    if (pe) hold(pb, BITC);
  endtask

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 valid", rx_valid, 0);
    check("R9 flags", {par_err, frm_err, brk_flag, brk_end}, 0);
    rst_n = 1'b1;
    hold(1'b1, 4 * BITC);

    // table walk (R2, R4, R5, R6, R7)
    for (int k = 0; k < 10; k++) begin
      logic [15:0] v;
      v = VEC[k];
      par_en = v[7]; par_odd = v[6];
      e0 = n_end;
      send_head(v[15:8], v[7], v[5]);
      hold(v[4], BITC);
      if (v[0]) begin
        hold(1'b0, 2 * BITC);
        check("R7 no end while low", n_end - e0, 0);
      end
      hold(1'b1, 3 * BITC);
      check("R2 valid", rx_valid, v[3]);
      if (v[3]) check("R2 data", rx_data, v[15:8]);
      check("R4 par_err", par_err, v[2]);
      check("R5 frm_err", frm_err, v[1]);
      check("R6 brk_flag", brk_flag, v[0]);
      check("R7 brk_end count", n_end - e0, v[0]);
      pulse_clr();
    end
    par_en = 1'b0; par_odd = 1'b0;

    // R1: short false start
    hold(1'b0, 8);
    hold(1'b1, 12 * BITC);
    check("R1 no char", rx_valid, 0);
    check("R1 no flags", {par_err, frm_err, brk_flag}, 0);

    // R3: withheld ready
    send_head(8'hC3, 1'b0, 1'b0);
    hold(1'b1, 4 * BITC);
    check("R3 valid held", rx_valid, 1);
    check("R3 data held", rx_data, 8'hC3);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    check("R3 cleared by handshake", rx_valid, 0);

    // R5: framing flag before stop bit ends
    send_head(8'h5A, 1'b0, 1'b0);
    hold(1'b0, 26);
    check("R5 early frm_err", frm_err, 1);
    hold(1'b0, BITC - 26);
    hold(1'b1, 2 * BITC);
    // R8: sta_clr clears flags, keeps character
    sta_clr = 1'b1; @(negedge clk); sta_clr = 1'b0;
    check("R8 frm cleared", frm_err, 0);
    check("R8 valid kept", rx_valid, 1);
    check("R8 data kept", rx_data, 8'h5A);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;

    // R7: glitch during recovery restarts count, no frame started
    e0 = n_end;
    send_head(8'h00, 1'b0, 1'b0);
    hold(1'b0, 2 * BITC);
    check("R6 break seen", brk_flag, 1);
    hold(1'b1, 20);
    hold(1'b0, 20);
    hold(1'b1, 20);
    check("R7 no early end", n_end - e0, 0);
    hold(1'b1, 2 * BITC);
    check("R7 end pulse once", n_end - e0, 1);
    check("R7 no char from glitch", rx_valid, 0);
    pulse_clr();
    send_head(8'h96, 1'b0, 1'b0);
    hold(1'b1, 3 * BITC);
    check("R2 char after break", rx_data, 8'h96);
    check("R2 valid after break", rx_valid, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule